// File: doc/BRIEF.md
# DRAM Bank Boundary Decoder

This block turns a set of programmed boundary registers into the address windows of eight DRAM banks. It then reports the total memory they cover, and it decodes a probe address into a per-bank hit vector. Each boundary is put together from an 8-bit field, which gives address bits [27:20], and a 2-bit extension field, which gives bits [31:30]. The granularity is therefore 1 MiB. The registers come in two sets: a low set for banks 0 to 3 and a high set for banks 4 to 7. Inside each register, every bank owns one byte lane.

A one-cycle `mem_go` pulse starts a scan. The scan visits the banks one per clock, from bank 0 up to bank 7. For each enabled bank it adds that bank's size to a running total. It also checks that each enabled bank after bank 0 starts exactly where the memory counted so far ends. When the scan finishes, a one-cycle done pulse presents the final total and a gap warning. Address decoding runs all the time, independently of the scan, against the live register values.

Top module: `dram_bank_map`

## Requirements
- R1: Bank b takes its fields from byte lane b mod 4 (bits 8*(b mod 4)+7 down to 8*(b mod 4)) of four registers. Banks 0 to 3 use the low set (`base_lo`, `xbase_lo`, `top_lo`, `xtop_lo`) and banks 4 to 7 use the high set. An extension field is the lowest 2 bits of the bank's lane. The other 6 bits of that lane are ignored.
- R2: A bank's first address has the start extension in bits [31:30], the start field in bits [27:20], and zeros everywhere else. Its last address is built the same way from the end fields, with bits [19:0] forced to ones.
- R3: After a scan, `total_size` equals the sum of (last − first + 1) over all enabled banks, modulo 2^35. With no bank enabled it is 0.
- R4: `gap_warn` after a scan is 1 if any enabled bank with index above 0 has a first address that differs from the sum of the sizes of the enabled banks below it. Otherwise it is 0. Bank 0 never raises it.
- R5: A `mem_go` sampled at clock edge E0 while idle makes `map_done` high for exactly one cycle, following edge E8. `total_size` and `gap_warn` then hold their values until the next accepted `mem_go`.
- R6: A `mem_go` that arrives while a scan is in progress is ignored. It neither restarts nor extends the scan.
- R7: Bit b of `hit_vec` is 1 when `bank_en[b]` is 1 and the probe address lies in bank b's window, bounds included. The result is registered, so it follows `probe_addr`, `bank_en` and the boundary registers by one clock edge. A disabled bank never hits, whatever its window.
- R8: `unmapped` is 1, registered with `hit_vec`, exactly when no bit of `hit_vec` is set.
- R9: During reset and just after it, `hit_vec`, `unmapped`, `total_size`, `gap_warn` and `map_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_en | input | 8 | One enable bit per bank |
| base_lo | input | 32 | Start fields, banks 0-3 |
| base_hi | input | 32 | Start fields, banks 4-7 |
| xbase_lo | input | 32 | Start extension fields, banks 0-3 |
| xbase_hi | input | 32 | Start extension fields, banks 4-7 |
| top_lo | input | 32 | End fields, banks 0-3 |
| top_hi | input | 32 | End fields, banks 4-7 |
| xtop_lo | input | 32 | End extension fields, banks 0-3 |
| xtop_hi | input | 32 | End extension fields, banks 4-7 |
| mem_go | input | 1 | Start pulse for the size scan |
| probe_addr | input | 32 | Address to decode |
| hit_vec | output | 8 | Per-bank hit, registered |
| unmapped | output | 1 | No bank hit, registered |
| total_size | output | 35 | Accumulated memory size in bytes |
| map_done | output | 1 | One-cycle scan completion pulse |
| gap_warn | output | 1 | Non-contiguous bank layout seen |

## Verification
The scan results are due exactly nine falling edges after the falling edge that drives `mem_go`. That is one edge to accept the pulse and eight edges to visit the banks. The bench checks that `map_done` is still low one falling edge earlier and low again one falling edge later. The hit vector and the unmapped flag trail their inputs by a single edge. The bench drives them on a falling edge, confirms that the old value is still present right after the change, and reads the new value on the next falling edge. Because the bench samples only on falling edges, every read lands between two active edges.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

   typedef enum logic [0:0] {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_e;

endpackage

// File: rtl/dbm_lane_extract.sv
// Builds one bank's first and last address from its lane fields.
module dbm_lane_extract #(
   parameter int ADDR_W     = 32,
   parameter int FIELD_W    = 8,
   parameter int XFIELD_W   = 2,
   parameter int GRAN_SHIFT = 20
) (
   input  logic [FIELD_W-1:0]  lo_field,
   input  logic [XFIELD_W-1:0] lo_xfield,
   input  logic [FIELD_W-1:0]  hi_field,
   input  logic [XFIELD_W-1:0] hi_xfield,
   output logic [ADDR_W-1:0]   first_addr,
   output logic [ADDR_W-1:0]   last_addr
);

   localparam int XLSB = ADDR_W - XFIELD_W;

   always_comb begin
      first_addr = '0;
      first_addr[XLSB +: XFIELD_W]      = lo_xfield;
      first_addr[GRAN_SHIFT +: FIELD_W] = lo_field;

      last_addr = '0;
      last_addr[XLSB +: XFIELD_W]       = hi_xfield;
      last_addr[GRAN_SHIFT +: FIELD_W]  = hi_field;
      last_addr[GRAN_SHIFT-1:0]         = '1;
   end

endmodule

// File: rtl/dbm_scan.sv
// Sequential size accumulation and contiguity check, one bank per clock.
module dbm_scan
   import dbm_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int ADDR_W    = 32,
   parameter int SIZE_W    = 35
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              go,
   input  logic [NUM_BANKS-1:0]              en,
   input  logic [NUM_BANKS-1:0][ADDR_W-1:0]  first_addr,
   input  logic [NUM_BANKS-1:0][ADDR_W-1:0]  last_addr,
   output logic                              busy,
   output logic                              done,
   output logic [SIZE_W-1:0]                 total,
   output logic                              warn
);

   localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);

   scan_state_e       state;
   logic [IDX_W-1:0]  idx;
   logic [SIZE_W-1:0] span;
   logic [SIZE_W-1:0] cur_first;
   logic              gap_here;

   always_comb begin
      cur_first = SIZE_W'(first_addr[idx]);
      span      = SIZE_W'(last_addr[idx]) - cur_first + SIZE_W'(1);
      gap_here  = (idx != '0) && (cur_first != total);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SCAN_IDLE;
         idx   <= '0;
         total <= '0;
         warn  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            SCAN_IDLE: begin
               if (go) begin
                  state <= SCAN_RUN;
                  idx   <= '0;
                  total <= '0;
                  warn  <= 1'b0;
               end
            end
            default: begin
               if (en[idx]) begin
                  total <= total + span;
                  if (gap_here) begin
                     warn <= 1'b1;
                  end
               end
               if (idx == LAST_IDX) begin
                  state <= SCAN_IDLE;
                  done  <= 1'b1;
               end else begin
                  idx <= idx + IDX_W'(1);
               end
            end
         endcase
      end
   end

   assign busy = (state == SCAN_RUN);

endmodule

// File: rtl/dbm_match.sv
// Window compare of the probe address against every bank.
module dbm_match #(
   parameter int NUM_BANKS = 8,
   parameter int ADDR_W    = 32,
   parameter bit REG_HIT   = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [NUM_BANKS-1:0]              en,
   input  logic [NUM_BANKS-1:0][ADDR_W-1:0]  first_addr,
   input  logic [NUM_BANKS-1:0][ADDR_W-1:0]  last_addr,
   output logic [NUM_BANKS-1:0]              hit,
   output logic                              miss
);

   logic [NUM_BANKS-1:0] raw_hit;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
      assign raw_hit[b] = en[b] && (addr >= first_addr[b]) && (addr <= last_addr[b]);
   end

   if (REG_HIT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hit  <= '0;
            miss <= 1'b0;
         end else begin
            hit  <= raw_hit;
            miss <= (raw_hit == '0);
         end
      end
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign hit  = raw_hit;
      assign miss = (raw_hit == '0);
   end

endmodule

// File: rtl/dram_bank_map.sv
module dram_bank_map #(
   parameter int ADDR_W     = 32,
   parameter int FIELD_W    = 8,
   parameter int XFIELD_W   = 2,
   parameter int GRAN_SHIFT = 20,
   parameter int LANES      = 4,
   parameter int NUM_BANKS  = 8,
   parameter bit REG_HIT    = 1'b1,
   localparam int SIZE_W    = ADDR_W + $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] bank_en,
   input  logic [ADDR_W-1:0]    base_lo,
   input  logic [ADDR_W-1:0]    base_hi,
   input  logic [ADDR_W-1:0]    xbase_lo,
   input  logic [ADDR_W-1:0]    xbase_hi,
   input  logic [ADDR_W-1:0]    top_lo,
   input  logic [ADDR_W-1:0]    top_hi,
   input  logic [ADDR_W-1:0]    xtop_lo,
   input  logic [ADDR_W-1:0]    xtop_hi,
   input  logic                 mem_go,
   input  logic [ADDR_W-1:0]    probe_addr,
   output logic [NUM_BANKS-1:0] hit_vec,
   output logic                 unmapped,
   output logic [SIZE_W-1:0]    total_size,
   output logic                 map_done,
   output logic                 gap_warn
);

   // elaboration-time parameter checks
   if (NUM_BANKS != 2 * LANES) begin : g_bad_banks
      $error("NUM_BANKS must be twice LANES");
   end
   if (LANES * FIELD_W != ADDR_W) begin : g_bad_lanes
      $error("lanes must tile the register width");
   end
   if (XFIELD_W > FIELD_W) begin : g_bad_xfield
      $error("extension field wider than a lane");
   end
   if (GRAN_SHIFT < 1 || GRAN_SHIFT + FIELD_W > ADDR_W - XFIELD_W) begin : g_bad_gran
      $error("field placement overlaps the extension bits");
   end

   logic [NUM_BANKS-1:0][ADDR_W-1:0] first_addr;
   logic [NUM_BANKS-1:0][ADDR_W-1:0] last_addr;
   logic                             scan_busy;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int LSB = (b % LANES) * FIELD_W;
      logic [ADDR_W-1:0] s_reg, xs_reg, e_reg, xe_reg;

      if (b < LANES) begin : g_low_set
         assign s_reg  = base_lo;
         assign xs_reg = xbase_lo;
         assign e_reg  = top_lo;
         assign xe_reg = xtop_lo;
      end else begin : g_high_set
         assign s_reg  = base_hi;
         assign xs_reg = xbase_hi;
         assign e_reg  = top_hi;
         assign xe_reg = xtop_hi;
      end

      dbm_lane_extract #(
         .ADDR_W    (ADDR_W),
         .FIELD_W   (FIELD_W),
         .XFIELD_W  (XFIELD_W),
         .GRAN_SHIFT(GRAN_SHIFT)
      ) u_extract (
         .lo_field  (s_reg[LSB +: FIELD_W]),
         .lo_xfield (xs_reg[LSB +: XFIELD_W]),
         .hi_field  (e_reg[LSB +: FIELD_W]),
         .hi_xfield (xe_reg[LSB +: XFIELD_W]),
         .first_addr(first_addr[b]),
         .last_addr (last_addr[b])
      );
   end

   // upper bits of each extension lane carry no meaning
   logic unused_xlane_bits;
   assign unused_xlane_bits = ^{xbase_lo, xbase_hi, xtop_lo, xtop_hi};

   dbm_scan #(
      .NUM_BANKS(NUM_BANKS),
      .ADDR_W   (ADDR_W),
      .SIZE_W   (SIZE_W)
   ) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (mem_go),
      .en        (bank_en),
      .first_addr(first_addr),
      .last_addr (last_addr),
      .busy      (scan_busy),
      .done      (map_done),
      .total     (total_size),
      .warn      (gap_warn)
   );

   dbm_match #(
      .NUM_BANKS(NUM_BANKS),
      .ADDR_W   (ADDR_W),
      .REG_HIT  (REG_HIT)
   ) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (probe_addr),
      .en        (bank_en),
      .first_addr(first_addr),
      .last_addr (last_addr),
      .hit       (hit_vec),
      .miss      (unmapped)
   );

endmodule

// File: rtl/dram_bank_map_chk.sv
module dram_bank_map_chk #(
   parameter int NUM_BANKS = 8,
   parameter int SIZE_W    = 35,
   parameter bit REG_HIT   = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_BANKS-1:0] bank_en,
   input logic                 mem_go,
   input logic                 scan_busy,
   input logic [NUM_BANKS-1:0] hit_vec,
   input logic [SIZE_W-1:0]    total_size,
   input logic                 map_done,
   input logic                 gap_warn
);

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      map_done |=> !map_done);

   assert_done_after_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
      map_done |-> $past(scan_busy));

   assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_busy && !mem_go) |=> ($stable(total_size) && $stable(gap_warn)));

   assert_go_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_go && !scan_busy) |=> ((total_size == '0) && !gap_warn));

   assert_scan_runs_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
      scan_busy |=> (scan_busy || map_done));

   if (REG_HIT) begin : g_hit_chk
      assert_hit_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ((hit_vec & ~$past(bank_en)) == '0));
   end

endmodule

bind dram_bank_map dram_bank_map_chk #(
   .NUM_BANKS(NUM_BANKS),
   .SIZE_W   (SIZE_W),
   .REG_HIT  (REG_HIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bank_en   (bank_en),
   .mem_go    (mem_go),
   .scan_busy (scan_busy),
   .hit_vec   (hit_vec),
   .total_size(total_size),
   .map_done  (map_done),
   .gap_warn  (gap_warn)
);

// File: tb/dram_bank_map_bench.sv
`timescale 1ns/1ps
module dram_bank_map_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bank_en = '0;
   logic [31:0] base_lo = '0, base_hi = '0, xbase_lo = '0, xbase_hi = '0;
   logic [31:0] top_lo = '0, top_hi = '0, xtop_lo = '0, xtop_hi = '0;
   logic        mem_go = 1'b0;
   logic [31:0] probe_addr = '0;
   logic [7:0]  hit_vec;
   logic        unmapped;
   logic [34:0] total_size;
   logic        map_done;
   logic        gap_warn;

   int n_total = 0;
   int n_bad   = 0;

   always #4 clk = ~clk;

   dram_bank_map u_dram_bank_map (
      .clk(clk), .rst_n(rst_n), .bank_en(bank_en),
      .base_lo(base_lo), .base_hi(base_hi), .xbase_lo(xbase_lo), .xbase_hi(xbase_hi),
      .top_lo(top_lo), .top_hi(top_hi), .xtop_lo(xtop_lo), .xtop_hi(xtop_hi),
      .mem_go(mem_go), .probe_addr(probe_addr), .hit_vec(hit_vec),
      .unmapped(unmapped), .total_size(total_size), .map_done(map_done),
      .gap_warn(gap_warn)
   );

   typedef struct packed {
      logic [7:0]  en;
      logic [31:0] bl, bh, xbl, xbh, tl, th, xtl, xth;
      logic [34:0] total;
      logic        warn;
      logic [31:0] probe;
      logic [7:0]  hit;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      // single bank 0, 16 MiB
      '{8'h01, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000000F, 32'h0, 32'h0, 32'h0,
        35'h001000000, 1'b0, 32'h00FFFFFF, 8'h01},
      // banks 0,1 back to back
      '{8'h03, 32'h00001000, 32'h0, 32'h0, 32'h0, 32'h00001F0F, 32'h0, 32'h0, 32'h0,
        35'h002000000, 1'b0, 32'h01000000, 8'h02},
      // bank 0 plus bank 4 from the high set
      '{8'h11, 32'h0, 32'h00000040, 32'h0, 32'h0, 32'h0000003F, 32'h0000007F, 32'h0, 32'h0,
        35'h008000000, 1'b0, 32'h04000000, 8'h10},
      // only bank 1, starting above zero
      '{8'h02, 32'h00001000, 32'h0, 32'h0, 32'h0, 32'h00001F00, 32'h0, 32'h0, 32'h0,
        35'h001000000, 1'b1, 32'h00000000, 8'h00},
      // end extension bits on bank 0
      '{8'h01, 32'h0, 32'h0, 32'h0, 32'h0, 32'h000000FF, 32'h0, 32'h00000001, 32'h0,
        35'h050000000, 1'b0, 32'h4FFFFFFF, 8'h01},
      // nothing enabled
      '{8'h00, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        35'h000000000, 1'b0, 32'h00000000, 8'h00},
      // banks 0 and 2 with a hole
      '{8'h05, 32'h00200000, 32'h0, 32'h0, 32'h0, 32'h002F000F, 32'h0, 32'h0, 32'h0,
        35'h002000000, 1'b1, 32'h02800000, 8'h04},
      // only bank 7, lane 3 of high set; disabled bank 0 also covers addr 0
      '{8'h80, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h07000000, 32'h0, 32'h0,
        35'h000800000, 1'b0, 32'h00000000, 8'h80}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_total++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic neg();
      @(negedge clk);
   endtask

   task automatic load(input vec_t v);
      bank_en = v.en;
      base_lo = v.bl;  base_hi = v.bh;  xbase_lo = v.xbl; xbase_hi = v.xbh;
      top_lo  = v.tl;  top_hi  = v.th;  xtop_lo  = v.xtl; xtop_hi  = v.xth;
      probe_addr = v.probe;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_total++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

   initial begin
      // R9: reset state
      repeat (3) neg();
      check("R9 hit_vec in reset", 64'(hit_vec), 64'h0);
      check("R9 unmapped in reset", 64'(unmapped), 64'h0);
      check("R9 total in reset", 64'(total_size), 64'h0);
      check("R9 done/warn in reset", 64'({map_done, gap_warn}), 64'h0);
      rst_n = 1'b1;
      neg();
      check("R9 done after reset", 64'(map_done), 64'h0);
      check("R9 total after reset", 64'(total_size), 64'h0);

      // table walk: R1/R2 field mapping, R3 total, R4 gaps, R5 timing, R7/R8 decode
      for (int i = 0; i < NV; i++) begin
         load(VECS[i]);
         mem_go = 1'b1;
         neg();
         mem_go = 1'b0;
         repeat (7) neg();
         check($sformatf("R5 done early v%0d", i), 64'(map_done), 64'h0);
         neg();
         check($sformatf("R5 done v%0d", i), 64'(map_done), 64'h1);
         check($sformatf("R3 total v%0d", i), 64'(total_size), 64'(VECS[i].total));
         check($sformatf("R4 gap v%0d", i), 64'(gap_warn), 64'(VECS[i].warn));
         check($sformatf("R7 hit v%0d", i), 64'(hit_vec), 64'(VECS[i].hit));
         check($sformatf("R8 unmapped v%0d", i), 64'(unmapped), 64'(VECS[i].hit == 8'h0));
         neg();
         check($sformatf("R5 done one cycle v%0d", i), 64'(map_done), 64'h0);
         check($sformatf("R5 total held v%0d", i), 64'(total_size), 64'(VECS[i].total));
      end

      // R7 latency and boundaries on the bank 0 + bank 4 layout
      load(VECS[2]);
      probe_addr = 32'h03FFFFFF;
      neg();
      check("R7 last byte of bank 0", 64'(hit_vec), 64'h01);
      probe_addr = 32'h04000000;
      #1;
      check("R7 hit holds before edge", 64'(hit_vec), 64'h01);
      neg();
      check("R7 first byte of bank 4", 64'(hit_vec), 64'h10);
      probe_addr = 32'h08000000;
      neg();
      check("R8 past last bank", 64'({unmapped, hit_vec}), 64'h100);
      // R1: bits above the extension field inside a lane are ignored
      xtop_lo = 32'h000000FC;
      probe_addr = 32'h03FFFFFF;
      neg();
      check("R1 upper lane bits ignored", 64'(hit_vec), 64'h01);
      xtop_lo = 32'h0;
      // R7: enable removed, window unchanged
      bank_en = 8'h10;
      neg();
      check("R7 disabled bank no hit", 64'({unmapped, hit_vec}), 64'h100);

      // R6: second go during scan is ignored
      load(VECS[0]);
      mem_go = 1'b1;
      neg();
      mem_go = 1'b0;
      repeat (2) neg();
      mem_go = 1'b1;
      neg();
      mem_go = 1'b0;
      repeat (4) neg();
      check("R6 done not early", 64'(map_done), 64'h0);
      neg();
      check("R6 done at first-go time", 64'(map_done), 64'h1);
      check("R6 total", 64'(total_size), 64'h001000000);
      for (int k = 0; k < 5; k++) begin
         neg();
         check("R6 no second done", 64'(map_done), 64'h0);
      end

      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

endmodule